// File: doc/BRIEF.md
# Delay-Line Tap Controller with Rollover Detection

This block is the digital half of a delay-locked loop. It holds a tap index into a 128-stage delay chain. While the loop runs, it moves that index by at most one stage on each update. The direction comes from an early/late phase comparison. The analog chain and the phase comparator sit outside the block. Only the two comparator decisions come in, and the tap index goes out, visible on every clock.

The loop runs while an enable derived from a nonzero clock ratio is high. When that enable is low, the index is frozen and no updates occur. A new enable restarts the index from the middle of the chain, and updates then come once every eight clocks. A lock flag reports that the loop is dithering around its target. An optional rollover guard watches for the index parked on the last stage or wrapping across the chain end. When the guard is armed, either event raises a sticky checkstop.

Top module: `dll_tap_ctrl`

## Requirements
- R1: After a synchronous reset, tap_count is 64, locked is 0 and checkstop is 0.
- R2: On the first clock edge where dll_en is sampled high after having been low (or after reset), tap_count loads 64. The first update is applied 8 clock edges later.
- R3: While enabled, an update is applied every 8 clock edges. Early high with late low adds one to tap_count. Late high with early low subtracts one. Both high or both low leave it unchanged.
- R4: tap_count counts modulo 128. Adding one at 127 gives 0, and subtracting one at 0 gives 127.
- R5: While dll_en is low, tap_count holds its value whatever early/late do, and locked reads 0.
- R6: locked becomes 1 on the update that completes 16 consecutive direction reversals. A reversal is a step opposite to the previous step. Updates that do not move are ignored for this count.
- R7: locked returns to 0 on the update that completes a run of 4 steps in the same direction. A same-direction step resets the reversal count.
- R8: When rollover_chk_en is high and the loop is enabled with tap_count at 127, checkstop is 1 from the next clock edge on.
- R9: When rollover_chk_en is high and an update wraps tap_count across the chain end, checkstop is 1 on the same edge that applies the wrap.
- R10: checkstop stays 1 until reset, even after rollover_chk_en drops. It never rises while rollover_chk_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dll_en | input | 1 | Loop enable (clock ratio nonzero) |
| early | input | 1 | Comparator says add delay |
| late | input | 1 | Comparator says remove delay |
| rollover_chk_en | input | 1 | Arms the rollover checkstop |
| tap_count | output | 7 | Current delay tap index |
| locked | output | 1 | Loop dithering around its target |
| checkstop | output | 1 | Sticky rollover checkstop |

## Verification
The main run feeds a strictly alternating early/late pattern, which must set the lock only at the sixteenth reversal. It then adds a hold update and a both-asserted update, which must neither move the tap nor disturb the lock. A one-directional run follows, which must drop the lock at its fourth step. Long monotonic climbs and descents walk the index to both chain ends. They show whether a parked-at-last-stage condition raises checkstop one clock after the index arrives, or whether a wrap raises it on the wrap edge itself. Disabled intervals with a comparator decision asserted separate a frozen index from one that keeps stepping.

// File: rtl/dll_pkg.sv
package dll_pkg;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'b00,
        DIR_UP   = 2'b01,
        DIR_DOWN = 2'b10
    } step_dir_e;

    typedef struct packed {
        logic      valid;
        step_dir_e dir;
    } step_req_t;

    function automatic step_dir_e decode_dir(input logic early, input logic late);
        if (early && !late)
            return DIR_UP;
        else if (late && !early)
            return DIR_DOWN;
        else
            return DIR_HOLD;
    endfunction

endpackage

// File: rtl/dll_update_timer.sv
module dll_update_timer #(
    parameter int INTERVAL = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic start,
    output logic tick
);
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || start)
            cnt <= '0;
        else if (cnt == LAST_CNT)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && !start && (cnt == LAST_CNT);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R3

endmodule

// File: rtl/dll_tap_counter.sv
module dll_tap_counter
    import dll_pkg::*;
#(
    parameter int TAP_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  step_req_t        req,
    output logic [TAP_W-1:0] tap,
    output logic             wrap
);
    localparam logic [TAP_W-1:0] MID  = TAP_W'(1) << (TAP_W - 1);
    localparam logic [TAP_W-1:0] LAST = '1;
    localparam logic [TAP_W-1:0] ONE  = TAP_W'(1);

    always_ff @(posedge clk) begin
        if (rst || load)
            tap <= MID;
        else if (req.valid) begin
            case (req.dir)
                DIR_UP:   tap <= tap + ONE;
                DIR_DOWN: tap <= tap - ONE;
                default:  tap <= tap;
            endcase
        end
    end

    assign wrap = req.valid &&
                  (((req.dir == DIR_UP)   && (tap == LAST)) ||
                   ((req.dir == DIR_DOWN) && (tap == '0)));

    AST_STEP_UNIT: assert property (@(posedge clk) disable iff (rst || load)
        (req.valid && req.dir != DIR_HOLD) |=>
            ((tap == $past(tap) + ONE) || (tap == $past(tap) - ONE))); // R3

    AST_IDLE_STILL: assert property (@(posedge clk) disable iff (rst || load)
        (!req.valid || req.dir == DIR_HOLD) |=> $stable(tap)); // R3

endmodule

// File: rtl/dll_lock_tracker.sv
module dll_lock_tracker
    import dll_pkg::*;
#(
    parameter int REVERSALS = 16,
    parameter int RUN       = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  step_req_t req,
    output logic      locked
);
    localparam int RW = $clog2(REVERSALS + 1);
    localparam int SW = $clog2(RUN + 1);
    localparam logic [RW-1:0] REV_MAX = RW'(REVERSALS);
    localparam logic [SW-1:0] RUN_MAX = SW'(RUN);

    logic          have_last, have_last_n;
    step_dir_e     last_dir, last_dir_n;
    logic [RW-1:0] rev_cnt, rev_n;
    logic [SW-1:0] run_cnt, run_n;
    logic          locked_n;
    logic          moving, reversal;

    assign moving   = req.valid && (req.dir != DIR_HOLD);
    assign reversal = have_last && (req.dir != last_dir);

    always_comb begin
        have_last_n = have_last;
        last_dir_n  = last_dir;
        rev_n       = rev_cnt;
        run_n       = run_cnt;
        locked_n    = locked;
        if (moving) begin
            have_last_n = 1'b1;
            last_dir_n  = req.dir;
            if (reversal) begin
                rev_n = (rev_cnt == REV_MAX) ? REV_MAX : rev_cnt + 1'b1;
                run_n = SW'(1);
            end else begin
                rev_n = '0;
                run_n = (run_cnt == RUN_MAX) ? RUN_MAX : run_cnt + 1'b1;
            end
            if (rev_n == REV_MAX)
                locked_n = 1'b1;
            else if (run_n == RUN_MAX)
                locked_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have_last <= 1'b0;
            last_dir  <= DIR_HOLD;
            rev_cnt   <= '0;
            run_cnt   <= '0;
            locked    <= 1'b0;
        end else begin
            have_last <= have_last_n;
            last_dir  <= last_dir_n;
            rev_cnt   <= rev_n;
            run_cnt   <= run_n;
            locked    <= locked_n;
        end
    end

    AST_LOCK_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(moving)); // R6

    AST_UNLOCK_ON_UPDATE: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> ($past(moving) || $past(clear))); // R7

    AST_OFF_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
        clear |=> !locked); // R5

endmodule

// File: rtl/dll_rollover_guard.sv
module dll_rollover_guard #(
    parameter int TAP_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             chk_en,
    input  logic [TAP_W-1:0] tap,
    input  logic             wrap,
    output logic             checkstop
);
    localparam logic [TAP_W-1:0] LAST = '1;

    logic at_edge;
    assign at_edge = active && (tap == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            checkstop <= 1'b0;
        else if (chk_en && (at_edge || wrap))
            checkstop <= 1'b1;
    end

    AST_CHECKSTOP_STICKY: assert property (@(posedge clk) disable iff (rst)
        checkstop |=> checkstop); // R10

    AST_CHECKSTOP_ARMED: assert property (@(posedge clk) disable iff (rst)
        $rose(checkstop) |-> $past(chk_en)); // R10

    AST_WRAP_TRIPS: assert property (@(posedge clk) disable iff (rst)
        (chk_en && wrap) |=> checkstop); // R9

endmodule

// File: rtl/dll_tap_ctrl.sv
module dll_tap_ctrl
    import dll_pkg::*;
#(
    parameter int TAP_W          = 7,
    parameter int STEP_INTERVAL  = 8,
    parameter int LOCK_REVERSALS = 16,
    parameter int UNLOCK_RUN     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dll_en,
    input  logic             early,
    input  logic             late,
    input  logic             rollover_chk_en,
    output logic [TAP_W-1:0] tap_count,
    output logic             locked,
    output logic             checkstop
);
    logic      en_q;
    logic      load;
    logic      tick;
    logic      wrap;
    step_req_t req;

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b0;
        else
            en_q <= dll_en;
    end

    assign load      = dll_en && !en_q;
    assign req.valid = tick;
    assign req.dir   = decode_dir(early, late);

    dll_update_timer #(.INTERVAL(STEP_INTERVAL)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (dll_en),
        .start (load),
        .tick  (tick)
    );

    dll_tap_counter #(.TAP_W(TAP_W)) u_taps (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .req  (req),
        .tap  (tap_count),
        .wrap (wrap)
    );

    dll_lock_tracker #(.REVERSALS(LOCK_REVERSALS), .RUN(UNLOCK_RUN)) u_lock (
        .clk    (clk),
        .rst    (rst),
        .clear  (!dll_en),
        .req    (req),
        .locked (locked)
    );

    dll_rollover_guard #(.TAP_W(TAP_W)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .active    (dll_en),
        .chk_en    (rollover_chk_en),
        .tap       (tap_count),
        .wrap      (wrap),
        .checkstop (checkstop)
    );

    AST_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !dll_en |=> $stable(tap_count)); // R5

    AST_LOAD_MID: assert property (@(posedge clk) disable iff (rst)
        (dll_en && !en_q) |=> (tap_count == (TAP_W'(1) << (TAP_W - 1)))); // R2

endmodule

// File: tb/sim_dll_tap_ctrl.sv
`timescale 1ns/1ps
module sim_dll_tap_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dll_en = 1'b0;
    logic       early = 1'b0;
    logic       late = 1'b0;
    logic       rollover_chk_en = 1'b0;
    logic [6:0] tap_count;
    logic       locked;
    logic       checkstop;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    dll_tap_ctrl u0 (
        .clk             (clk),
        .rst             (rst),
        .dll_en          (dll_en),
        .early           (early),
        .late            (late),
        .rollover_chk_en (rollover_chk_en),
        .tap_count       (tap_count),
        .locked          (locked),
        .checkstop       (checkstop)
    );

    // {early, late, expected locked, expected tap}
    localparam logic [9:0] VEC [0:22] = '{
        {2'b10, 1'b0, 7'd65}, {2'b01, 1'b0, 7'd64}, {2'b10, 1'b0, 7'd65},
        {2'b01, 1'b0, 7'd64}, {2'b10, 1'b0, 7'd65}, {2'b01, 1'b0, 7'd64},
        {2'b10, 1'b0, 7'd65}, {2'b01, 1'b0, 7'd64}, {2'b10, 1'b0, 7'd65},
        {2'b01, 1'b0, 7'd64}, {2'b10, 1'b0, 7'd65}, {2'b01, 1'b0, 7'd64},
        {2'b10, 1'b0, 7'd65}, {2'b01, 1'b0, 7'd64}, {2'b10, 1'b0, 7'd65},
        {2'b01, 1'b0, 7'd64}, {2'b10, 1'b1, 7'd65}, {2'b00, 1'b1, 7'd65},
        {2'b11, 1'b1, 7'd65}, {2'b10, 1'b1, 7'd66}, {2'b10, 1'b1, 7'd67},
        {2'b10, 1'b0, 7'd68}, {2'b01, 1'b0, 7'd67}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_step(input logic e, input logic l);
        early = e;
        late  = l;
        repeat (8) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 tap", int'(tap_count), 64);
        chk("R1 locked", int'(locked), 0);
        chk("R1 checkstop", int'(checkstop), 0);

        rst = 1'b0;
        dll_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 load mid", int'(tap_count), 64);

        // Table walk: R3 stepping, R6 lock set, R7 lock clear
        for (int i = 0; i < 23; i++) begin
            do_step(VEC[i][9], VEC[i][8]);
            chk($sformatf("R3 R6 R7 vec%0d tap", i), int'(tap_count), int'(VEC[i][6:0]));
            chk($sformatf("R6 R7 vec%0d locked", i), int'(locked), int'(VEC[i][7]));
        end

        // R6: relock with alternating steps
        for (int i = 0; i < 8; i++) begin
            do_step(1'b1, 1'b0);
            do_step(1'b0, 1'b1);
        end
        chk("R6 relock", int'(locked), 1);
        chk("R3 alt tap", int'(tap_count), 67);

        // R5: disabled freezes tap, clears lock
        dll_en = 1'b0;
        early = 1'b1;
        late = 1'b0;
        repeat (40) @(posedge clk);
        @(negedge clk);
        chk("R5 frozen tap", int'(tap_count), 67);
        chk("R5 unlocked", int'(locked), 0);

        // R2: re-enable reloads mid
        dll_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R2 reload", int'(tap_count), 64);
        // first update exactly 8 edges after load
        repeat (7) @(posedge clk);
        @(negedge clk);
        chk("R2 no early step", int'(tap_count), 64);
        @(posedge clk);
        @(negedge clk);
        chk("R2 first step", int'(tap_count), 65);

        // climb to 127 with guard disarmed
        for (int i = 0; i < 62; i++) do_step(1'b1, 1'b0);
        chk("R3 climb", int'(tap_count), 127);
        @(posedge clk);
        @(negedge clk);
        chk("R10 disarmed", int'(checkstop), 0);
        // finish this interval so the next step task is aligned
        repeat (7) @(posedge clk);
        @(negedge clk);
        chk("R4 wrap up", int'(tap_count), 0);
        chk("R10 disarmed wrap", int'(checkstop), 0);

        // R9: armed wrap 0 -> 127 trips on the wrap edge
        rollover_chk_en = 1'b1;
        do_step(1'b0, 1'b1);
        chk("R4 wrap down", int'(tap_count), 127);
        chk("R9 wrap trip", int'(checkstop), 1);

        // R10: sticky after disarm
        rollover_chk_en = 1'b0;
        do_step(1'b1, 1'b0);
        chk("R10 sticky", int'(checkstop), 1);
        chk("R4 wrap up again", int'(tap_count), 0);

        // R1: reset clears checkstop
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R1 checkstop cleared", int'(checkstop), 0);
        chk("R1 tap reset", int'(tap_count), 64);
        rst = 1'b0;
        rollover_chk_en = 1'b1;
        @(posedge clk);
        @(negedge clk);

        // R8: park at last tap trips one clock later
        for (int i = 0; i < 62; i++) do_step(1'b1, 1'b0);
        chk("R8 pre tap", int'(tap_count), 126);
        chk("R8 pre checkstop", int'(checkstop), 0);
        do_step(1'b1, 1'b0);
        chk("R8 at last", int'(tap_count), 127);
        chk("R8 not yet", int'(checkstop), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R8 tripped", int'(checkstop), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule